// File: doc/BRIEF.md
# Multi-Channel Interval Timer Bank

This block provides a bank of independent down-counting timers behind a simple synchronous register bus. Each channel has a control register, an interval (reload) register and a live count register. A channel picks one of four tick-enable sources and divides that source by a power of two from 1 to 128. Every prescaled tick lowers the count by one. When the count would pass from 1 to 0, or when it is already 0, the channel expires. It then reloads (periodic mode), or it stops and clears its own enable bit (one-shot mode).

An expiry sets the channel's bit in a shared status register. Software clears that bit by writing a 1 to it. A shared enable mask gates each status bit onto the channel's own interrupt line. The tick sources arrive as single-cycle enables in the bus clock domain. A parameter marks which sources are present, and a control write that names an absent source cannot start the channel.

The bus is combinational on read: `bus_rdata` reflects `bus_addr` in the same cycle. Writes take effect at the rising edge where `bus_we` is high.

Top module: `pit_bank`

## Requirements
- R1: After reset, the interrupt enable, status, every interval and every count read 0. Every control register reads 0x04 (source 1, divide by 1, stopped, periodic). All interrupt outputs are low.
- R2: Interrupt enable is at offset 0x00 and status at 0x04. Channel n has control at 0x10*(n+1), interval at +0x4 and count at +0x8. Reads of any other offset return 0, and writes to them change no register.
- R3: The control layout is: bit 0 enable, bit 1 reload, bits [3:2] source, bits [6:4] prescale exponent, bit 7 one-shot. A control write with bit 1 set copies the interval into the count. Bit 1 always reads back as 0.
- R4: While enabled, a channel lowers its count by one on every 2^exp-th pulse of its selected source, counted from the last control write. Pulses on the other sources have no effect.
- R5: On a prescaled tick with count 0 or 1, the channel's status bit is set. In periodic mode the count is reloaded from the interval, so an interval of 0 expires on every tick.
- R6: In one-shot mode an expiry leaves the count at 0 and clears control bit 0.
- R7: A write to status clears each bit written as 1 and leaves the others. An expiry in the same cycle wins over the clear.
- R8: Each interrupt line equals its status bit ANDed with its enable bit, from the edge after either register changes.
- R9: A control write that selects an absent source keeps the previous source and exponent fields and leaves the channel stopped. Source 3 is absent by default.
- R10: Writes to a count register are ignored. An interval write does not alter a running count.
- R11: A stopped channel holds its count and does not expire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | Tick enables of the four clock sources |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 6 | Per-channel interrupt lines |

## Verification
Directed sequences try short periodic runs, a one-shot run, an interval of zero and an absent source. The periodic and one-shot runs are told apart by whether the count reloads or stays at 0 and by the enable bit that reads back afterwards. Source pulses are sent on unselected sources and interleaved with selected ones, which separates correct source selection from counting every pulse. Random runs vary the interval, exponent, source, mode and pulse density. They compare the count, the status bit, the enable bit and the interrupt line against a bench model, which exposes off-by-one faults in the prescaler and at the 1-to-0 expiry point.

// File: rtl/pit_pkg.sv
package pit_pkg;
   localparam int ADDR_W   = 8;
   localparam int SRC_N    = 4;
   localparam int EXP_W    = 3;
   localparam int CTL_W    = 8;

   localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h00;
   localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h04;
   localparam logic [3:0]        SUB_CTL    = 4'h0;
   localparam logic [3:0]        SUB_IVL    = 4'h4;
   localparam logic [3:0]        SUB_CNT    = 4'h8;

   typedef struct packed {
      logic             oneshot;
      logic [EXP_W-1:0] pexp;
      logic [1:0]       src;
      logic             reload;
      logic             en;
   } ctl_t;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler
   import pit_pkg::*;
#(
   parameter int NSRC = SRC_N,
   parameter int XW   = EXP_W
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NSRC-1:0]         src_tick,
   input  logic [$clog2(NSRC)-1:0] sel,
   input  logic [XW-1:0]           pexp,
   input  logic                    run,
   input  logic                    clr,
   output logic                    ptick
);
   localparam int PRE_W = (1 << XW) - 1;

   logic [PRE_W-1:0] pcnt;
   logic [PRE_W-1:0] mask;
   logic             stick;

   assign stick = src_tick[sel];
   assign mask  = (PRE_W'(1) << pexp) - PRE_W'(1);
   assign ptick = run && !clr && stick && ((pcnt & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) pcnt <= '0;
      else if (run && stick) pcnt <= pcnt + PRE_W'(1);
   end

   p_tick_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ptick |-> (stick && run));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int         DATA_W      = 32,
   parameter logic [3:0] SRC_PRESENT = 4'b0111,
   parameter logic [7:0] CTL_DEFAULT = 8'h04
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_N-1:0]  src_tick,
   input  logic              ctl_wr,
   input  logic              ivl_wr,
   input  logic [DATA_W-1:0] wdata,
   output ctl_t              ctl,
   output logic [DATA_W-1:0] ivl,
   output logic [DATA_W-1:0] cnt,
   output logic              expire
);
   ctl_t wctl;
   logic src_ok;
   logic ptick;
   logic last;

   assign wctl   = ctl_t'(wdata[CTL_W-1:0]);
   assign src_ok = SRC_PRESENT[wctl.src];
   assign last   = (cnt <= DATA_W'(1));
   assign expire = ptick && last;

   pit_prescaler #(.NSRC(SRC_N), .XW(EXP_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .sel(ctl.src),
      .pexp(ctl.pexp), .run(ctl.en), .clr(ctl_wr), .ptick(ptick));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl <= ctl_t'(CTL_DEFAULT);
         ivl <= '0;
         cnt <= '0;
      end else begin
         if (ivl_wr) ivl <= wdata;
         if (ctl_wr) begin
            ctl.oneshot <= wctl.oneshot;
            ctl.reload  <= 1'b0;
            ctl.en      <= wctl.en && src_ok;
            if (src_ok) begin
               ctl.pexp <= wctl.pexp;
               ctl.src  <= wctl.src;
            end
            if (wctl.reload) cnt <= ivl;
         end else if (ptick) begin
            if (last) begin
               cnt <= ctl.oneshot ? '0 : ivl;
               if (ctl.oneshot) ctl.en <= 1'b0;
            end else begin
               cnt <= cnt - DATA_W'(1);
            end
         end
      end
   end

   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ptick && !ctl_wr && !last) |=> (cnt == $past(cnt) - DATA_W'(1)));
   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !ctl.oneshot) |=> (cnt == $past(ivl)));
   p_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctl.oneshot) |=> (!ctl.en && cnt == '0));
   p_absent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !src_ok) |=> !ctl.en);
   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.en && !ctl_wr) |=> $stable(cnt));
endmodule

// File: rtl/pit_bank.sv
module pit_bank
   import pit_pkg::*;
#(
   parameter int         NUM_CH      = 6,
   parameter int         DATA_W      = 32,
   parameter logic [3:0] SRC_PRESENT = 4'b0111,
   parameter logic [7:0] CTL_DEFAULT = 8'h04
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        src_tick,
   input  logic [7:0]        bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [5:0]        irq
);
   generate
      if (NUM_CH != 6) begin : g_bad_ch
         $error("pit_bank: port widths assume NUM_CH == 6");
      end
      if (DATA_W != 32) begin : g_bad_w
         $error("pit_bank: port widths assume DATA_W == 32");
      end
   endgenerate

   logic [NUM_CH-1:0] ien, status, expv, ctl_wr, ivl_wr;
   logic [DATA_W-1:0] ivl_q [NUM_CH];
   logic [DATA_W-1:0] cnt_q [NUM_CH];
   ctl_t              ctl_q [NUM_CH];
   logic              st_wr;

   assign st_wr = bus_we && (bus_addr == OFS_STAT);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit       = (bus_addr[7:4] == 4'(i + 1));
      assign ctl_wr[i] = bus_we && hit && (bus_addr[3:0] == SUB_CTL);
      assign ivl_wr[i] = bus_we && hit && (bus_addr[3:0] == SUB_IVL);

      pit_channel #(.DATA_W(DATA_W), .SRC_PRESENT(SRC_PRESENT),
                    .CTL_DEFAULT(CTL_DEFAULT)) u_ch (
         .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
         .ctl_wr(ctl_wr[i]), .ivl_wr(ivl_wr[i]), .wdata(bus_wdata),
         .ctl(ctl_q[i]), .ivl(ivl_q[i]), .cnt(cnt_q[i]), .expire(expv[i]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien    <= '0;
         status <= '0;
      end else begin
         if (bus_we && bus_addr == OFS_IEN) ien <= bus_wdata[NUM_CH-1:0];
         status <= (status & ~(st_wr ? bus_wdata[NUM_CH-1:0] : '0)) | expv;
      end
   end

   assign irq = status & ien;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == OFS_IEN)       bus_rdata = 32'(ien);
      else if (bus_addr == OFS_STAT) bus_rdata = 32'(status);
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr[7:4] == 4'(i + 1)) begin
            case (bus_addr[3:0])
               SUB_CTL: bus_rdata = 32'(ctl_q[i]);
               SUB_IVL: bus_rdata = ivl_q[i];
               SUB_CNT: bus_rdata = cnt_q[i];
               default: bus_rdata = '0;
            endcase
         end
      end
   end

   p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && expv == '0) |=> ((status & $past(bus_wdata[NUM_CH-1:0])) == '0));
   p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (expv != '0) |=> ((status & $past(expv)) == $past(expv)));
endmodule

// File: tb/sim_pit_bank.sv
module sim_pit_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src_tick = '0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [5:0]  irq;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   pit_bank u0 (.clk(clk), .rst_n(rst_n), .src_tick(src_tick),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b0;
      #1 d = bus_rdata;
   endtask

   task automatic pulse(input logic [3:0] v, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         src_tick = v;
         @(negedge clk);
         src_tick = '0;
      end
   endtask

   // model of a channel after p prescaled ticks: {en, status, count}
   function automatic logic [33:0] model(input int ivl, input bit one, input int p);
      int  c = ivl;
      bit  en = 1'b1;
      bit  st = 1'b0;
      for (int k = 0; k < p; k++) begin
         if (!en) break;
         if (c <= 1) begin
            st = 1'b1;
            if (one) begin c = 0; en = 1'b0; end
            else c = ivl;
         end else c--;
      end
      return {en, st, 32'(c)};
   endfunction

   initial begin
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int seed_dummy;
      seed_dummy = $urandom(7);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h10, d); chk("R1 ctl0", d, 32'h04);
      rd(8'h60, d); chk("R1 ctl5", d, 32'h04);
      rd(8'h14, d); chk("R1 ivl0", d, 0);
      rd(8'h58, d); chk("R1 cnt4", d, 0);
      rd(8'h00, d); chk("R1 ien", d, 0);
      rd(8'h04, d); chk("R1 stat", d, 0);
      chk("R1 irq", 32'(irq), 0);

      // R2 map and unmapped offsets
      wr(8'h64, 32'd123);
      rd(8'h64, d); chk("R2 ivl5", d, 123);
      rd(8'h0C, d); chk("R2 unmapped 0C", d, 0);
      rd(8'h1C, d); chk("R2 unmapped 1C", d, 0);
      wr(8'h0C, 32'hFFFF_FFFF);
      wr(8'h7C, 32'hFFFF_FFFF);
      rd(8'h00, d); chk("R2 ien after unmapped wr", d, 0);
      rd(8'h70, d); chk("R2 offset 70 reads zero", d, 0);

      // R3 reload and self-clearing bit
      wr(8'h14, 32'd10);
      wr(8'h10, 32'h07);
      rd(8'h10, d); chk("R3 ctl readback", d, 32'h05);
      rd(8'h18, d); chk("R3 count loaded", d, 10);

      // R4 counting on selected source only
      pulse(4'b0010, 3);
      rd(8'h18, d); chk("R4 three ticks", d, 7);
      pulse(4'b1101, 4);
      rd(8'h18, d); chk("R4 other sources ignored", d, 7);

      // R10 count writes ignored, interval write keeps count
      wr(8'h18, 32'd999);
      rd(8'h18, d); chk("R10 count write ignored", d, 7);
      wr(8'h14, 32'd20);
      rd(8'h18, d); chk("R10 interval write", d, 7);

      // R5 periodic expiry
      pulse(4'b0010, 6);
      rd(8'h18, d); chk("R5 count at one", d, 1);
      rd(8'h04, d); chk("R5 no status yet", d, 0);
      pulse(4'b0010, 1);
      rd(8'h18, d); chk("R5 reloaded", d, 20);
      rd(8'h04, d); chk("R5 status set", d, 1);
      chk("R8 irq masked", 32'(irq), 0);
      wr(8'h00, 32'h01);
      chk("R8 irq enabled", 32'(irq), 1);
      wr(8'h04, 32'h02);
      rd(8'h04, d); chk("R7 other bit kept", d, 1);
      wr(8'h04, 32'h01);
      rd(8'h04, d); chk("R7 cleared", d, 0);
      chk("R8 irq low after clear", 32'(irq), 0);
      wr(8'h10, 32'h04);   // stop ch0

      // R6 one-shot
      wr(8'h24, 32'd2);
      wr(8'h20, 32'h87);
      pulse(4'b0010, 2);
      rd(8'h20, d); chk("R6 enable cleared", d, 32'h84);
      rd(8'h28, d); chk("R6 count zero", d, 0);
      rd(8'h04, d); chk("R6 status", d, 32'h02);
      wr(8'h04, 32'h02);
      // R11 stopped channel
      pulse(4'b0010, 5);
      rd(8'h04, d); chk("R11 no expiry when stopped", d, 0);
      rd(8'h28, d); chk("R11 count held", d, 0);

      // R5 interval zero
      wr(8'h30, 32'h07);
      pulse(4'b0010, 1);
      rd(8'h04, d); chk("R5 zero interval expires", d, 32'h04);
      wr(8'h30, 32'h04);
      wr(8'h04, 32'h3F);

      // R9 absent source
      wr(8'h40, 32'h3D);
      rd(8'h40, d); chk("R9 absent source", d, 32'h04);
      pulse(4'b1111, 3);
      rd(8'h48, d); chk("R9 channel not started", d, 0);

      // R4 prescaler divide by 4
      wr(8'h44, 32'd9);
      wr(8'h40, 32'h23);
      pulse(4'b0001, 7);
      rd(8'h48, d); chk("R4 divide by four", d, 8);
      wr(8'h40, 32'h20);

      // random runs on channel 4
      for (int it = 0; it < 24; it++) begin
         int ivl, ex, src, k, p;
         bit one, ie;
         logic [33:0] m;
         ivl = $urandom_range(0, 12);
         ex  = $urandom_range(0, 3);
         src = $urandom_range(0, 2);
         one = $urandom_range(0, 1);
         ie  = $urandom_range(0, 1);
         wr(8'h00, {31'd0, ie} << 4);
         wr(8'h54, 32'(ivl));
         wr(8'h50, {24'd0, one, 3'(ex), 2'(src), 2'b11});
         wr(8'h04, 32'h10);
         k = 0;
         for (int n = 0; n < $urandom_range(0, 60); n++) begin
            logic [3:0] v;
            v = 4'($urandom_range(0, 15));
            if (v[src]) k++;
            pulse(v, 1);
         end
         p = k >> ex;
         m = model(ivl, one, p);
         rd(8'h58, d); chk("R5 random count", d, m[31:0]);
         rd(8'h04, d); chk("R5 random status", 32'(d[4]), 32'(m[32]));
         rd(8'h50, d); chk("R6 random enable", 32'(d[0]), 32'(m[33]));
         chk("R8 random irq", 32'(irq[4]), 32'(m[32] & ie));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule